// File: doc/BRIEF.md
# Byte-Wide Command/Data Host Handshake

This block is the host-side handshake for an 8-bit legacy mode of a disc-drive controller. Host accesses come in on active-low read and write strobes. A command/data select input steers each access either to the command/status path or to the data path. Only the low byte of the 16-bit host bus carries anything. The strobes are asynchronous to the block clock, so they pass through a two-flop synchroniser before any edge detection. An access is taken on the third rising clock edge after its strobe falls. It ends on the third rising edge after both strobes have gone high again.

The controller side loads two counts. The first is the number of pending status bytes. The second is the length and direction of a data block transfer. The block shows both counts to the host through active-low "status available" and "data available" outputs. It pulls an end-of-transfer output low during the access that moves the final data byte. It also drives one shared line that changes role with a mode input. In PIO mode the line is an active-low wait that stretches each host cycle. In DMA mode the line is an active-high request. The status byte source and the data buffer sit outside the block and are reached through pop and push pulses.

Top module: `byte_host_link`

## Requirements
- R1: After reset, `sts_rdy_n`, `dat_rdy_n` and `eot_n` are 1, `hst_d_oe` is 0, `wait_drq` is 1, and none of `cmd_valid`, `sts_pop`, `buf_pop` or `buf_push` is asserted.
- R2: `hst_d_out[15:8]` is always 0, and the value on `hst_d_in[15:8]` has no effect on any byte the block captures.
- R3: A write with `hst_cd`=1 (command/status select) gives a one-cycle `cmd_valid` pulse, with `cmd_byte` equal to `hst_d_in[7:0]`.
- R4: `sts_rdy_n` is 0 exactly while the pending-status count loaded through `sts_load`/`sts_len` is nonzero. A read with `hst_cd`=1 drives `sts_byte` onto `hst_d_out[7:0]` with `hst_d_oe`=1. At the end of that read the block pulses `sts_pop` and lowers the count by one, so `sts_rdy_n` returns to 1 after the last pending byte has been read.
- R5: `dat_rdy_n` is 0 exactly while the data count loaded through `xfer_load`/`xfer_len` is nonzero. The largest count the width allows is accepted.
- R6: With `xfer_to_host`=1 latched at load, a read with `hst_cd`=0 drives `buf_rd_byte` onto the bus. At the end of that read the block pulses `buf_pop` and lowers the data count by exactly one.
- R7: With `xfer_to_host`=0 latched at load, a write with `hst_cd`=0 pulses `buf_push` with `buf_wr_byte` equal to `hst_d_in[7:0]`. The data count drops by one when the access ends.
- R8: `eot_n` is 0 only during a data access made while the remaining count is one, that is, during the transfer of the final byte.
- R9: With `hst_pio`=1, `wait_drq` goes to 0 on the edge that takes an access and stays 0 for STRETCH clock cycles, then returns to 1.
- R10: With `hst_pio`=0, `wait_drq` is 1 while the data count is nonzero and no access is in progress. Otherwise it is 0, and it follows with one register of delay.
- R11: The following accesses are ignored, meaning they produce no pulse, no bus drive and no change to either count: a status read with no status pending, a data access when the data count is zero, and a data access against the loaded direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| hst_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| hst_cd | input | 1 | 1 selects command/status, 0 selects data |
| hst_pio | input | 1 | 1 selects PIO (wait role), 0 selects DMA (request role) |
| hst_d_in | input | 16 | Host data bus in; only bits 7:0 are used |
| hst_d_out | output | 16 | Host data bus out; bits 15:8 are always 0 |
| hst_d_oe | output | 1 | Host bus output enable |
| sts_rdy_n | output | 1 | Status available, active low |
| dat_rdy_n | output | 1 | Data available, active low |
| eot_n | output | 1 | Final-byte strobe, active low |
| wait_drq | output | 1 | Shared wait / DMA request line |
| cmd_valid | output | 1 | One-cycle pulse for a captured command byte |
| cmd_byte | output | 8 | Captured command byte |
| sts_load | input | 1 | Load the pending status count |
| sts_len | input | SC_W | Number of pending status bytes |
| sts_byte | input | 8 | Next status byte from the controller |
| sts_pop | output | 1 | Pulse: a status byte has been consumed |
| xfer_load | input | 1 | Load the data count and direction |
| xfer_len | input | CNT_W | Data transfer length in bytes |
| xfer_to_host | input | 1 | 1 means host reads data, 0 means host writes data |
| buf_rd_byte | input | 8 | Next data byte for the host |
| buf_pop | output | 1 | Pulse: a data byte has been read by the host |
| buf_push | output | 1 | Pulse: a data byte from the host is valid |
| buf_wr_byte | output | 8 | Data byte written by the host |

## Verification
The bench builds the block with CNT_W=4, SC_W=3 and STRETCH=3. A 4-bit count makes the largest legal transfer only fifteen bytes, so a full-length block, with the final-byte strobe seen on its last access only, fits in a short run. A three-cycle stretch ends well inside one host access, so both the falling and the rising edge of the wait window can be sampled in the same access. A 3-bit status count keeps the multi-byte status drain short while still testing more than one pending byte.

// File: rtl/bhl_pkg.sv
package bhl_pkg;

    typedef enum logic [2:0] {
        ACC_NONE   = 3'd0,
        ACC_CMD_WR = 3'd1,
        ACC_STS_RD = 3'd2,
        ACC_DAT_RD = 3'd3,
        ACC_DAT_WR = 3'd4,
        ACC_IGNORE = 3'd5
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e   kind;
        logic [7:0]  dout;
        logic        oe;
        logic        cmd_v;
        logic [7:0]  cmd_b;
        logic        push;
        logic [7:0]  wr_b;
        logic        pop;
        logic        spop;
        logic        dir;
    } link_state_t;

    function automatic logic is_data_kind(acc_kind_e k);
        return (k == ACC_DAT_RD) || (k == ACC_DAT_WR);
    endfunction

endpackage

// File: rtl/bhl_sync.sv
module bhl_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] in_n,
    output logic [N-1:0] lvl_n,
    output logic [N-1:0] fall
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = in_n;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: '1, s2: '1, s3: '1};
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign lvl_n[i] = st_q.s2[i];
        assign fall[i]  = st_q.s3[i] & ~st_q.s2[i];
    end

endmodule

// File: rtl/bhl_counter.sv
module bhl_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] count,
    output logic         zero,
    output logic         one
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
    assign zero  = (cnt_q == '0);
    assign one   = (cnt_q == ONE);

    // R5: an empty counter stays empty unless reloaded
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);

    // R6: without a load the count moves down by at most one per cycle
    a_r6_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !zero) |=> ((count == $past(count)) || (count == $past(count) - ONE)));

endmodule

// File: rtl/bhl_line.sv
module bhl_line #(
    parameter int STRETCH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pio_mode,
    input  logic start,
    input  logic busy,
    input  logic cnt_nz,
    output logic line
);
    localparam int SW = $clog2(STRETCH + 2);
    localparam logic [SW-1:0] STR_VAL = SW'(STRETCH);

    typedef struct packed {
        logic [SW-1:0] stretch;
        logic          line;
    } line_t;

    line_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.stretch = STR_VAL;
        end else if (st_q.stretch != '0) begin
            st_d.stretch = st_q.stretch - SW'(1);
        end
        if (pio_mode) begin
            st_d.line = (st_d.stretch == '0);
        end else begin
            st_d.line = cnt_nz && !busy;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{stretch: '0, line: 1'b1};
        else        st_q <= st_d;
    end

    assign line = st_q.line;

    // R9: an accepted access in PIO mode pulls the wait line low at once
    a_r9_stretch_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (pio_mode && start && (STRETCH > 0)) |=> !line);

    // R10: in DMA mode the request drops while an access is in progress
    a_r10_drq_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!pio_mode && busy) |=> (pio_mode || !line));

endmodule

// File: rtl/byte_host_link.sv
module byte_host_link
    import bhl_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int SC_W    = 4,
    parameter int STRETCH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hst_rd_n,
    input  logic             hst_wr_n,
    input  logic             hst_cd,
    input  logic             hst_pio,
    input  logic [15:0]      hst_d_in,
    output logic [15:0]      hst_d_out,
    output logic             hst_d_oe,
    output logic             sts_rdy_n,
    output logic             dat_rdy_n,
    output logic             eot_n,
    output logic             wait_drq,
    output logic             cmd_valid,
    output logic [7:0]       cmd_byte,
    input  logic             sts_load,
    input  logic [SC_W-1:0]  sts_len,
    input  logic [7:0]       sts_byte,
    output logic             sts_pop,
    input  logic             xfer_load,
    input  logic [CNT_W-1:0] xfer_len,
    input  logic             xfer_to_host,
    input  logic [7:0]       buf_rd_byte,
    output logic             buf_pop,
    output logic             buf_push,
    output logic [7:0]       buf_wr_byte
);
    localparam int STB_N  = 2;
    localparam int IDX_RD = 0;
    localparam int IDX_WR = 1;

    logic [STB_N-1:0] stb_lvl_n, stb_fall;
    logic [CNT_W-1:0] dat_count;
    logic [SC_W-1:0]  sts_count;
    logic             dat_zero, dat_one, sts_zero, sts_one;
    logic             dat_dec, sts_dec, acc_start, acc_busy;
    logic             unused_hi;

    link_state_t st_d, st_q;

    bhl_sync #(.N(STB_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .in_n  ({hst_wr_n, hst_rd_n}),
        .lvl_n (stb_lvl_n),
        .fall  (stb_fall)
    );

    bhl_counter #(.W(CNT_W)) u_dat_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (xfer_load),
        .load_val (xfer_len),
        .dec      (dat_dec),
        .count    (dat_count),
        .zero     (dat_zero),
        .one      (dat_one)
    );

    bhl_counter #(.W(SC_W)) u_sts_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sts_load),
        .load_val (sts_len),
        .dec      (sts_dec),
        .count    (sts_count),
        .zero     (sts_zero),
        .one      (sts_one)
    );

    always_comb begin
        st_d       = st_q;
        st_d.cmd_v = 1'b0;
        st_d.push  = 1'b0;
        st_d.pop   = 1'b0;
        st_d.spop  = 1'b0;
        dat_dec    = 1'b0;
        sts_dec    = 1'b0;
        acc_start  = 1'b0;

        if (xfer_load) st_d.dir = xfer_to_host;

        if (st_q.kind == ACC_NONE) begin
            if (stb_fall[IDX_RD]) begin
                acc_start = 1'b1;
                if (hst_cd) begin
                    if (!sts_zero) begin
                        st_d.kind = ACC_STS_RD;
                        st_d.dout = sts_byte;
                        st_d.oe   = 1'b1;
                    end else begin
                        st_d.kind = ACC_IGNORE;
                    end
                end else if (!dat_zero && st_q.dir) begin
                    st_d.kind = ACC_DAT_RD;
                    st_d.dout = buf_rd_byte;
                    st_d.oe   = 1'b1;
                end else begin
                    st_d.kind = ACC_IGNORE;
                end
            end else if (stb_fall[IDX_WR]) begin
                acc_start = 1'b1;
                if (hst_cd) begin
                    st_d.kind  = ACC_CMD_WR;
                    st_d.cmd_v = 1'b1;
                    st_d.cmd_b = hst_d_in[7:0];
                end else if (!dat_zero && !st_q.dir) begin
                    st_d.kind = ACC_DAT_WR;
                    st_d.push = 1'b1;
                    st_d.wr_b = hst_d_in[7:0];
                end else begin
                    st_d.kind = ACC_IGNORE;
                end
            end
        end else if (stb_lvl_n[IDX_RD] && stb_lvl_n[IDX_WR]) begin
            case (st_q.kind)
                ACC_STS_RD: begin
                    st_d.spop = 1'b1;
                    sts_dec   = 1'b1;
                end
                ACC_DAT_RD: begin
                    st_d.pop = 1'b1;
                    dat_dec  = 1'b1;
                end
                ACC_DAT_WR: begin
                    dat_dec = 1'b1;
                end
                default: ;
            endcase
            st_d.kind = ACC_NONE;
            st_d.oe   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{kind: ACC_NONE, dout: '0, oe: 1'b0, cmd_v: 1'b0,
                      cmd_b: '0, push: 1'b0, wr_b: '0, pop: 1'b0,
                      spop: 1'b0, dir: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_busy = (st_q.kind != ACC_NONE);

    bhl_line #(.STRETCH(STRETCH)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .pio_mode (hst_pio),
        .start    (acc_start),
        .busy     (acc_busy),
        .cnt_nz   (!dat_zero),
        .line     (wait_drq)
    );

    assign unused_hi   = ^{hst_d_in[15:8], sts_one, sts_count};
    assign hst_d_out   = {8'h00, st_q.dout};
    assign hst_d_oe    = st_q.oe;
    assign sts_rdy_n   = sts_zero;
    assign dat_rdy_n   = dat_zero;
    assign eot_n       = !(dat_one && is_data_kind(st_q.kind));
    assign cmd_valid   = st_q.cmd_v;
    assign cmd_byte    = st_q.cmd_b;
    assign sts_pop     = st_q.spop;
    assign buf_pop     = st_q.pop;
    assign buf_push    = st_q.push;
    assign buf_wr_byte = st_q.wr_b;

    // R11: at most one side-effect pulse per cycle
    a_r11_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid, sts_pop, buf_pop, buf_push}));

    // R6: a data pop only ever consumes a counted byte
    a_r6_pop_had_data: assert property (@(posedge clk) disable iff (!rst_n)
        buf_pop |-> ($past(dat_count) != '0));

    // R4: a status pop only happens while status was announced
    a_r4_spop_had_pending: assert property (@(posedge clk) disable iff (!rst_n)
        sts_pop |-> $past(!sts_rdy_n));

    // R8: the final-byte strobe implies data is still announced
    a_r8_eot_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        !eot_n |-> !dat_rdy_n);

endmodule

// File: tb/byte_host_link_test.sv
module byte_host_link_test;
    localparam int CNT_W   = 4;
    localparam int SC_W    = 3;
    localparam int STRETCH = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             hst_rd_n = 1'b1, hst_wr_n = 1'b1, hst_cd = 1'b0, hst_pio = 1'b1;
    logic [15:0]      hst_d_in = '0;
    logic [15:0]      hst_d_out;
    logic             hst_d_oe, sts_rdy_n, dat_rdy_n, eot_n, wait_drq;
    logic             cmd_valid, sts_pop, buf_pop, buf_push;
    logic [7:0]       cmd_byte, buf_wr_byte;
    logic             sts_load = 1'b0, xfer_load = 1'b0, xfer_to_host = 1'b0;
    logic [SC_W-1:0]  sts_len = '0;
    logic [CNT_W-1:0] xfer_len = '0;
    logic [7:0]       sts_byte = 8'h50, buf_rd_byte = 8'hA0;

    int total = 0;
    int bad   = 0;
    int pops  = 0;
    int spops = 0;
    bit done  = 1'b0;

    typedef struct packed { logic [7:0] tag; logic [7:0] b; } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    byte_host_link #(.CNT_W(CNT_W), .SC_W(SC_W), .STRETCH(STRETCH)) uut (
        .clk(clk), .rst_n(rst_n), .hst_rd_n(hst_rd_n), .hst_wr_n(hst_wr_n),
        .hst_cd(hst_cd), .hst_pio(hst_pio), .hst_d_in(hst_d_in),
        .hst_d_out(hst_d_out), .hst_d_oe(hst_d_oe), .sts_rdy_n(sts_rdy_n),
        .dat_rdy_n(dat_rdy_n), .eot_n(eot_n), .wait_drq(wait_drq),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .sts_load(sts_load),
        .sts_len(sts_len), .sts_byte(sts_byte), .sts_pop(sts_pop),
        .xfer_load(xfer_load), .xfer_len(xfer_len), .xfer_to_host(xfer_to_host),
        .buf_rd_byte(buf_rd_byte), .buf_pop(buf_pop), .buf_push(buf_push),
        .buf_wr_byte(buf_wr_byte)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: scoreboard for captured bytes, models the buffer/status sources
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (cmd_valid || buf_push) begin
                exp_t got;
                got.tag = cmd_valid ? 8'h43 : 8'h57;
                got.b   = cmd_valid ? cmd_byte : buf_wr_byte;
                if (exp_q.size() == 0) begin
                    chk("R3/R7 unexpected capture", {16'h0, got}, 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk("R3/R7 captured byte", {16'h0, got}, {16'h0, e});
                end
            end
            if (buf_pop) begin
                pops++;
                buf_rd_byte = 8'hA0 + 8'(pops);
            end
            if (sts_pop) begin
                spops++;
                sts_byte = 8'h50 + 8'(spops);
            end
        end
    end

    task automatic host_op(input logic rd, input logic cd, input logic [15:0] din,
                           output logic [7:0] rb, output logic [7:0] rhi, output logic roe,
                           output logic la, output logic lb, output logic eo);
        @(negedge clk);
        hst_cd   = cd;
        hst_d_in = din;
        if (rd) hst_rd_n = 1'b0; else hst_wr_n = 1'b0;
        repeat (4) @(negedge clk);
        la = wait_drq;
        repeat (3) @(negedge clk);
        lb = wait_drq;
        @(negedge clk);
        rb  = hst_d_out[7:0];
        rhi = hst_d_out[15:8];
        roe = hst_d_oe;
        eo  = eot_n;
        hst_rd_n = 1'b1;
        hst_wr_n = 1'b1;
        hst_d_in = 16'hFFFF;
        repeat (6) @(negedge clk);
    endtask

    task automatic push_exp(input logic [7:0] tag, input logic [7:0] b);
        exp_t e;
        e.tag = tag;
        e.b   = b;
        exp_q.push_back(e);
    endtask

    task automatic load_xfer(input logic [CNT_W-1:0] len, input logic dir);
        @(negedge clk);
        xfer_len = len; xfer_to_host = dir; xfer_load = 1'b1;
        @(negedge clk);
        xfer_load = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        logic [7:0] rb, rhi;
        logic roe, la, lb, eo;
        int p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 sts_rdy_n", sts_rdy_n, 1);
        chk("R1 dat_rdy_n", dat_rdy_n, 1);
        chk("R1 eot_n", eot_n, 1);
        chk("R1 wait_drq", wait_drq, 1);
        chk("R1 oe", hst_d_oe, 0);
        chk("R1 pulses", {cmd_valid, sts_pop, buf_pop, buf_push}, 0);

        // R3 + R2: command write, upper byte noise ignored
        push_exp(8'h43, 8'h3C);
        host_op(1'b0, 1'b1, 16'hAB3C, rb, rhi, roe, la, lb, eo);
        // R9: PIO stretch window of STRETCH cycles
        chk("R9 wait low early", la, 0);
        chk("R9 wait high after stretch", lb, 1);

        // R11: status read with nothing pending
        host_op(1'b1, 1'b1, 16'h0, rb, rhi, roe, la, lb, eo);
        chk("R11 no drive on empty status", roe, 0);
        chk("R11 no status pop", spops, 0);

        // R4: two pending status bytes
        @(negedge clk); sts_len = 3'd2; sts_load = 1'b1;
        @(negedge clk); sts_load = 1'b0;
        @(negedge clk);
        chk("R4 status announced", sts_rdy_n, 0);
        host_op(1'b1, 1'b1, 16'h0, rb, rhi, roe, la, lb, eo);
        chk("R4 first status byte", rb, 8'h50);
        chk("R4 status oe", roe, 1);
        chk("R2 upper out zero", rhi, 0);
        chk("R4 still pending", sts_rdy_n, 0);
        host_op(1'b1, 1'b1, 16'h0, rb, rhi, roe, la, lb, eo);
        chk("R4 second status byte", rb, 8'h51);
        chk("R4 cleared after last", sts_rdy_n, 1);
        chk("R4 pop count", spops, 2);

        // R11: data read with zero count
        p0 = pops;
        host_op(1'b1, 1'b0, 16'h0, rb, rhi, roe, la, lb, eo);
        chk("R11 no drive on empty data", roe, 0);
        chk("R11 no pop on empty data", pops, p0);

        // R5 R6 R8: three-byte read to host
        load_xfer(4'd3, 1'b1);
        chk("R5 data announced", dat_rdy_n, 0);
        chk("R8 idle eot", eot_n, 1);
        for (int i = 0; i < 3; i++) begin
            host_op(1'b1, 1'b0, 16'h0, rb, rhi, roe, la, lb, eo);
            chk("R6 read byte", rb, 8'hA0 + 8'(i));
            chk("R6 read oe", roe, 1);
            chk("R8 eot on last only", eo, (i == 2) ? 1'b0 : 1'b1);
        end
        chk("R6 pop count", pops, p0 + 3);
        chk("R5 data cleared", dat_rdy_n, 1);
        chk("R8 eot released", eot_n, 1);

        // R7 + R11 wrong direction
        load_xfer(4'd2, 1'b0);
        p0 = pops;
        host_op(1'b1, 1'b0, 16'h0, rb, rhi, roe, la, lb, eo);
        chk("R11 wrong-direction read not driven", roe, 0);
        chk("R11 wrong-direction no pop", pops, p0);
        chk("R11 count kept", dat_rdy_n, 0);
        push_exp(8'h57, 8'h11);
        host_op(1'b0, 1'b0, 16'h5511, rb, rhi, roe, la, lb, eo);
        chk("R8 not last", eo, 1);
        push_exp(8'h57, 8'h22);
        host_op(1'b0, 1'b0, 16'h9922, rb, rhi, roe, la, lb, eo);
        chk("R8 last write", eo, 0);
        chk("R7 done", dat_rdy_n, 1);

        // R5: full-length transfer at the count limit
        load_xfer(4'd15, 1'b0);
        for (int i = 0; i < 15; i++) begin
            push_exp(8'h57, 8'(i * 7 + 1));
            host_op(1'b0, 1'b0, {8'hEE, 8'(i * 7 + 1)}, rb, rhi, roe, la, lb, eo);
            chk("R5 max-length eot placement", eo, (i == 14) ? 1'b0 : 1'b1);
            chk("R5 max-length still pending", dat_rdy_n, (i == 14) ? 1'b1 : 1'b0);
        end

        // R10: DMA request role
        hst_pio = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 no request when empty", wait_drq, 0);
        load_xfer(4'd2, 1'b1);
        chk("R10 request when idle with data", wait_drq, 1);
        host_op(1'b1, 1'b0, 16'h0, rb, rhi, roe, la, lb, eo);
        chk("R10 request low during access", la, 0);
        chk("R10 request still low", lb, 0);
        chk("R10 request back between bytes", wait_drq, 1);
        host_op(1'b1, 1'b0, 16'h0, rb, rhi, roe, la, lb, eo);
        chk("R10 request off after last", wait_drq, 0);

        chk("R3/R7 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule